// File: doc/BRIEF.md
# Combinational Restoring Array Divider

This block divides one unsigned N-bit operand by another and returns an N-bit quotient and an N-bit remainder within the same cycle. It has no clock and holds no state. The logic is a square array with one row for each quotient bit. The first row produces the most significant quotient bit and the last row produces bit 0. Every row shifts the running partial remainder left by one place and moves the next dividend bit into its low end. It then subtracts the divisor with a rippling borrow chain. The borrow leaving the top cell of that chain is the row's sign. That sign selects, in every cell of the row, either the old shifted remainder or the new difference.

The design suits datapaths that can afford the full ripple delay in one cycle. That delay is roughly N rows times N+1 cells. A zero divisor is not flagged. It gives a quotient of all ones and a remainder equal to the dividend, and the surrounding logic may detect it on its own.

Top module: `rad_array_divider`

## Requirements
- R1: `quotient` and `remainder` are pure combinational functions of `dividend` and `divisor`. An input change is reflected in the same clock cycle, with no clock or reset involved.
- R2: For every nonzero divisor, `dividend = quotient * divisor + remainder`, evaluated as unsigned integers without truncation.
- R3: For every nonzero divisor, `remainder < divisor`.
- R4: Quotient bit N-1 is 1 exactly when the dividend's top bit, taken alone as a value, is at least the divisor. For a nonzero divisor this means divisor = 1 and dividend bit N-1 = 1.
- R5: With `divisor` = 0, `quotient` is all ones (2^N - 1).
- R6: With `divisor` = 0, `remainder` equals `dividend`.
- R7: With `divisor` = 1, `quotient` equals `dividend` and `remainder` is 0.
- R8: With a nonzero divisor greater than the dividend, `quotient` is 0 and `remainder` equals `dividend`.
- R9: The width parameter N (legal range 1 to 64) sets every port. At N = 8 the relations of R2, R3 and R5 still hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend | input | N | Unsigned dividend |
| divisor | input | N | Unsigned divisor; zero is allowed and is not flagged |
| quotient | output | N | Unsigned quotient; bit N-1 comes from the first row |
| remainder | output | N | Unsigned remainder after the last row |

## Verification
Both results are due zero cycles after a stimulus, because no register lies between the inputs and the outputs. The bench changes the operands one time unit after a rising clock edge. It reads `quotient` and `remainder` at the following falling edge, which is half a period later in the same cycle. Ripple settling is therefore complete before any compare, and no compare depends on the order of events at an edge. The bound checker evaluates its relations whenever the operands or results change.

// File: rtl/rad_pkg.sv
package rad_pkg;

   // Widest array the library accepts; bounds the square of cells.
   localparam int unsigned RAD_MAX_W = 64;

   // Difference bit of x - y - bin.
   function automatic logic rad_fs_diff(input logic x, input logic y, input logic bin);
      return x ^ y ^ bin;
   endfunction

   // Borrow out of x - y - bin: set when x < y + bin.
   function automatic logic rad_fs_borrow(input logic x, input logic y, input logic bin);
      return (~x & (y | bin)) | (y & bin);
   endfunction

endpackage

// File: rtl/rad_cell.sv
// One array cell: a full subtractor followed by a 2:1 restore multiplexer.
module rad_cell
   import rad_pkg::*;
(
   input  logic r_bit,     // shifted partial-remainder bit
   input  logic d_bit,     // divisor bit
   input  logic b_in,      // borrow from the cell to the right
   input  logic keep,      // row sign: 1 keeps r_bit, 0 takes the difference
   output logic b_out,     // borrow to the cell to the left
   output logic rem_bit    // selected remainder bit for the next row
);

   logic diff;

   assign diff    = rad_fs_diff(r_bit, d_bit, b_in);
   assign b_out   = rad_fs_borrow(r_bit, d_bit, b_in);
   assign rem_bit = keep ? r_bit : diff;

endmodule

// File: rtl/rad_sign_cell.sv
// Leftmost cell of a row: the divisor bit there is zero and only the borrow
// matters, because the selected remainder is truncated back to N bits.
module rad_sign_cell
   import rad_pkg::*;
(
   input  logic r_bit,
   input  logic b_in,
   output logic neg
);

   assign neg = rad_fs_borrow(r_bit, 1'b0, b_in);

endmodule

// File: rtl/rad_row.sv
// One quotient-bit row: shift in a dividend bit, subtract the divisor in N+1
// bits, and restore or update the partial remainder based on the borrow sign.
module rad_row #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] rem_in,
   input  logic         a_bit,
   input  logic [N-1:0] dvsr,
   output logic [N-1:0] rem_out,
   output logic         neg
);

   localparam int unsigned SW = N + 1;   // subtract width

   logic [SW-1:0] shifted;
   logic [SW-1:0] brw;                   // brw[j] = borrow into cell j

   assign shifted = {rem_in, a_bit};
   assign brw[0]  = 1'b0;

   for (genvar j = 0; j < N; j++) begin : g_cell
      rad_cell u_cell (
         .r_bit   (shifted[j]),
         .d_bit   (dvsr[j]),
         .b_in    (brw[j]),
         .keep    (neg),
         .b_out   (brw[j+1]),
         .rem_bit (rem_out[j])
      );
   end

   rad_sign_cell u_sign (
      .r_bit (shifted[SW-1]),
      .b_in  (brw[SW-1]),
      .neg   (neg)
   );

endmodule

// File: rtl/rad_array_divider.sv
// Fully unrolled unsigned restoring divider: N rows of N+1 ripple cells.
module rad_array_divider
   import rad_pkg::*;
#(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] dividend,
   input  logic [N-1:0] divisor,
   output logic [N-1:0] quotient,
   output logic [N-1:0] remainder
);

   if (N < 1 || N > RAD_MAX_W) begin : g_bad_width
      $error("rad_array_divider: N must lie in 1..%0d", RAD_MAX_W);
   end

   // part[i] is the partial remainder entering row i; part[0] starts at zero.
   logic [N-1:0] part [0:N];
   logic [N-1:0] row_neg;

   assign part[0] = '0;

   for (genvar i = 0; i < N; i++) begin : g_row
      rad_row #(.N(N)) u_row (
         .rem_in  (part[i]),
         .a_bit   (dividend[N-1-i]),
         .dvsr    (divisor),
         .rem_out (part[i+1]),
         .neg     (row_neg[i])
      );
      assign quotient[N-1-i] = ~row_neg[i];
   end

   assign remainder = part[N];

endmodule

// File: rtl/rad_array_divider_chk.sv
// Port-level relation checker bound to every divider instance.
module rad_array_divider_chk #(
   parameter int unsigned N = 4
) (
   input logic [N-1:0] a,
   input logic [N-1:0] b,
   input logic [N-1:0] q,
   input logic [N-1:0] r
);

   localparam int unsigned WW = 2 * N + 1;

   logic [WW-1:0] recon;
   logic [WW-1:0] a_wide;

   assign recon  = ({{(N+1){1'b0}}, q} * {{(N+1){1'b0}}, b}) + {{(N+1){1'b0}}, r};
   assign a_wide = {{(N+1){1'b0}}, a};

   always_comb begin
      if (b != '0) begin
         p_identity_r2: assert (recon == a_wide)
            else $error("R2 identity broken a=%0d b=%0d q=%0d r=%0d", a, b, q, r);
         p_rem_below_r3: assert (r < b)
            else $error("R3 remainder not below divisor r=%0d b=%0d", r, b);
         p_top_row_r4: assert (q[N-1] == ((b == N'(1)) && a[N-1]))
            else $error("R4 top quotient bit wrong a=%0d b=%0d", a, b);
         if (b == N'(1)) begin
            p_unit_r7: assert (q == a && r == '0)
               else $error("R7 unit divisor q=%0d r=%0d", q, r);
         end
         if (a < b) begin
            p_small_r8: assert (q == '0 && r == a)
               else $error("R8 small dividend q=%0d r=%0d", q, r);
         end
      end else begin
         p_zero_quot_r5: assert (q == '1)
            else $error("R5 zero divisor quotient %0d", q);
         p_zero_rem_r6: assert (r == a)
            else $error("R6 zero divisor remainder %0d", r);
      end
   end

endmodule

bind rad_array_divider rad_array_divider_chk #(.N(N)) u_chk (
   .a (dividend),
   .b (divisor),
   .q (quotient),
   .r (remainder)
);

// File: tb/rad_array_divider_bench.sv
`timescale 1ns/1ps
module rad_array_divider_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;   // 200 MHz

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   logic [3:0] a4 = '0, b4 = '0;
   logic [3:0] q4, r4;
   logic [7:0] a8 = '0, b8 = '0;
   logic [7:0] q8, r8;

   rad_array_divider #(.N(4)) u_rad_array_divider (
      .dividend (a4), .divisor (b4), .quotient (q4), .remainder (r4)
   );

   rad_array_divider #(.N(8)) u_rad_array_divider_w8 (
      .dividend (a8), .divisor (b8), .quotient (q8), .remainder (r8)
   );

   // {dividend, divisor, quotient, remainder}, 4 bits each
   localparam logic [15:0] VEC [0:11] = '{
      16'hD341, 16'hF1F0, 16'hFF10, 16'h7807, 16'h90F9, 16'h0500,
      16'hE432, 16'hC522, 16'h8240, 16'hB714, 16'h1110, 16'hF271
   };

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive4(input logic [3:0] a, input logic [3:0] b);
      @(posedge clk);
      #1;
      a4 = a;
      b4 = b;
      @(negedge clk);
   endtask

   task automatic drive8(input logic [7:0] a, input logic [7:0] b);
      @(posedge clk);
      #1;
      a8 = a;
      b8 = b;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL R1 watchdog actual %0d expected below 150000 cycles", cycles);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // Initial state: zero operands (R5, R6)
      @(negedge clk);
      chk("R5 initial quotient", q4, 15);
      chk("R6 initial remainder", r4, 0);

      // Table walk (R2 exact values; zero-divisor rows R5/R6)
      for (int k = 0; k < 12; k++) begin
         drive4(VEC[k][15:12], VEC[k][11:8]);
         chk(VEC[k][11:8] == 0 ? "R5 table quotient" : "R2 table quotient", q4, VEC[k][7:4]);
         chk(VEC[k][11:8] == 0 ? "R6 table remainder" : "R2 table remainder", r4, VEC[k][3:0]);
      end

      // R1: outputs follow a change within the same cycle
      drive4(4'd10, 4'd3);
      chk("R1 same-cycle quotient", q4, 3);
      chk("R1 same-cycle remainder", r4, 1);
      drive4(4'd10, 4'd4);
      chk("R1 follow-up quotient", q4, 2);
      chk("R1 follow-up remainder", r4, 2);

      // Exhaustive N = 4
      for (int ai = 0; ai < 16; ai++) begin
         for (int bi = 0; bi < 16; bi++) begin
            drive4(4'(ai), 4'(bi));
            if (bi == 0) begin
               chk("R5 zero divisor quotient", q4, 15);
               chk("R6 zero divisor remainder", r4, ai);
            end else begin
               chk("R2 quotient", q4, ai / bi);
               chk("R2 remainder", r4, ai % bi);
               chk("R2 identity", longint'(q4) * bi + r4, ai);
               chk("R3 remainder below divisor", (r4 < bi) ? 1 : 0, 1);
               chk("R4 top quotient bit", q4[3], (bi == 1 && ai >= 8) ? 1 : 0);
               if (bi == 1) begin
                  chk("R7 unit quotient", q4, ai);
                  chk("R7 unit remainder", r4, 0);
               end
               if (ai < bi) begin
                  chk("R8 small quotient", q4, 0);
                  chk("R8 small remainder", r4, ai);
               end
            end
         end
      end

      // N = 8: directed corners then random vectors (R9)
      drive8(8'd255, 8'd0);
      chk("R9 R5 wide zero divisor quotient", q8, 255);
      chk("R9 R6 wide zero divisor remainder", r8, 255);
      drive8(8'd255, 8'd255);
      chk("R9 wide equal quotient", q8, 1);
      chk("R9 wide equal remainder", r8, 0);
      drive8(8'd200, 8'd1);
      chk("R9 R7 wide unit quotient", q8, 200);
      drive8(8'd128, 8'd129);
      chk("R9 R8 wide small quotient", q8, 0);
      chk("R9 R8 wide small remainder", r8, 128);
      for (int n = 0; n < 600; n++) begin
         logic [7:0] ra;
         logic [7:0] rb;
         ra = 8'($urandom);
         rb = 8'($urandom);
         if (n % 7 == 0) rb = 8'(rb >> 5);
         drive8(ra, rb);
         if (rb == 0) begin
            chk("R9 R5 wide zero quotient", q8, 255);
         end else begin
            chk("R9 R2 wide identity", longint'(q8) * rb + r8, ra);
            chk("R9 R3 wide remainder below divisor", (r8 < rb) ? 1 : 0, 1);
            chk("R9 R2 wide quotient", q8, ra / rb);
         end
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule